// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets synchronous logic use an external asynchronous static RAM of 32K bytes. A host raises a request with a read/write flag, a 15-bit address and a write byte. The controller then runs one access on the memory pins: an active-low chip select, an active-low output enable, an active-low write strobe, the address bus and a bidirectional 8-bit data bus. Each access ends with a one-clock acknowledge. A read also returns the captured byte.

Each phase of an access lasts a fixed number of clocks, set by a parameter: address setup, write strobe width, data/address hold, read access window and release gap. The integrator picks each count as the memory's nanosecond limit divided by the clock period, rounded up, and never less than one. Output enable stays inactive for the whole of a write. The shorter write strobe width therefore applies, and the memory's outputs can never fight the controller's driver. The controller drives the data bus only while the strobe is low and during the hold phase that follows it. At all other times the bus is left floating.

Top module: `asram_ctrl`

## Requirements
- R1: While rst_n is low, mem_cs_n, mem_oe_n and mem_we_n are high and req_ack is low. This also applies when reset arrives in the middle of an access.
- R2: In the clock cycle of req_ack, mem_cs_n is already high. It stays high for at least TURN_CYC cycles, counting the acknowledge cycle, before the next access lowers it.
- R3: Every access starts with SETUP_CYC cycles in which mem_cs_n is low and both mem_oe_n and mem_we_n are high.
- R4: In a write, mem_we_n is low for exactly WE_CYC consecutive cycles.
- R5: mem_oe_n stays high for every cycle of a write. mem_oe_n and mem_we_n are never low in the same cycle.
- R6: After mem_we_n rises, mem_cs_n stays low for HOLD_CYC more cycles. The byte on mem_dq when mem_we_n rises is the request's write byte.
- R7: In a read, mem_oe_n is low for exactly ACCESS_CYC consecutive cycles, and mem_we_n stays high.
- R8: rsp_rdata shows the byte on mem_dq during the last low cycle of mem_oe_n. It is valid from the acknowledge cycle onward and keeps that value until the next read completes, so writes leave it unchanged.
- R9: req_ack is high for one cycle only. Count the clock edges from the edge that accepts a request up to and including the edge that raises req_ack. A write takes 1+SETUP_CYC+WE_CYC+HOLD_CYC of them and a read takes 1+SETUP_CYC+ACCESS_CYC.
- R10: In every cycle with mem_cs_n low, mem_addr equals the address of the access in progress.
- R11: req_addr, req_wdata and req_write are sampled only on the accepting edge, and changes to them during an access have no effect. If req_valid is still high when the release gap ends, the next access starts at once, so mem_cs_n is high for exactly TURN_CYC cycles between the two accesses.
- R12: When the controller is idle, a request is accepted on the first clock edge at which req_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request pending |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Byte to write |
| req_ack | output | 1 | One-cycle access completion |
| rsp_rdata | output | DATA_W | Byte captured by the last read |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq | inout | DATA_W | Memory data bus |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |

## Verification
A phase counter loaded with the wrong value shows up at the pins within one access. A strobe or output-enable window of the wrong length shows directly, and the acknowledge arrives early or late in the same transaction. A wrong next-phase decision shows as a strobe during a read, an output enable during a write, or a missing release gap, all before the acknowledge. A stale capture or request register shows only later, when the byte is read back or a back-to-back pair lands on the wrong address. For that reason the bench reads every written location back and changes the request fields while an access is running.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_PULSE,
    PH_HOLD,
    PH_READ,
    PH_RELEASE
  } phase_e;

  typedef struct packed {
    logic cs_n;
    logic oe_n;
    logic we_n;
    logic dq_en;
  } pins_t;

  // Pin levels that belong to each phase
  function automatic pins_t phase_pins(phase_e ph);
    pins_t p;
    p = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_en: 1'b0};
    case (ph)
      PH_ADDR:  p.cs_n = 1'b0;
      PH_PULSE: begin p.cs_n = 1'b0; p.we_n = 1'b0; p.dq_en = 1'b1; end
      PH_HOLD:  begin p.cs_n = 1'b0; p.dq_en = 1'b1; end
      PH_READ:  begin p.cs_n = 1'b0; p.oe_n = 1'b0; end
      default:  ;
    endcase
    return p;
  endfunction

  // Clock count spent in each phase
  function automatic int unsigned phase_len(phase_e ph, int unsigned s,
      int unsigned w, int unsigned h, int unsigned a, int unsigned t);
    case (ph)
      PH_ADDR:    return s;
      PH_PULSE:   return w;
      PH_HOLD:    return h;
      PH_READ:    return a;
      PH_RELEASE: return t;
      default:    return 1;
    endcase
  endfunction

  function automatic int unsigned max_of(int unsigned s, int unsigned w,
      int unsigned h, int unsigned a, int unsigned t);
    int unsigned m;
    m = s;
    if (w > m) m = w;
    if (h > m) m = h;
    if (a > m) m = a;
    if (t > m) m = t;
    return m;
  endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/asram_sequencer.sv
module asram_sequencer
  import asram_pkg::*;
#(
  parameter int unsigned SETUP_CYC  = 1,
  parameter int unsigned WE_CYC     = 2,
  parameter int unsigned HOLD_CYC   = 1,
  parameter int unsigned ACCESS_CYC = 3,
  parameter int unsigned TURN_CYC   = 1,
  parameter int unsigned CNT_W      = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_valid,
  input  logic  req_write,
  output logic  accept,
  output logic  capture,
  output pins_t pins,
  output logic  ack
);
  phase_e ph_q, ph_d;
  logic   wr_q;
  logic   last;
  logic   load;
  logic [CNT_W-1:0] load_val;

  always_comb begin
    ph_d = ph_q;
    case (ph_q)
      PH_IDLE:    if (req_valid) ph_d = PH_ADDR;
      PH_ADDR:    if (last) ph_d = wr_q ? PH_PULSE : PH_READ;
      PH_PULSE:   if (last) ph_d = PH_HOLD;
      PH_HOLD:    if (last) ph_d = PH_RELEASE;
      PH_READ:    if (last) ph_d = PH_RELEASE;
      PH_RELEASE: if (last) ph_d = req_valid ? PH_ADDR : PH_IDLE;
      default:    ph_d = PH_IDLE;
    endcase
  end

  assign accept   = (ph_d == PH_ADDR) && (ph_q != PH_ADDR);
  assign capture  = (ph_q == PH_READ) && last;
  assign load     = (ph_d != ph_q);
  assign load_val = CNT_W'(phase_len(ph_d, SETUP_CYC, WE_CYC, HOLD_CYC,
                                     ACCESS_CYC, TURN_CYC) - 1);

  asram_phase_timer #(.CNT_W(CNT_W)) i_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .last(last)
  );

  // Pins are registered from the next phase: no decode glitches on the strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
      wr_q <= 1'b0;
      pins <= '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_en: 1'b0};
      ack  <= 1'b0;
    end else begin
      ph_q <= ph_d;
      if (accept) wr_q <= req_write;
      pins <= phase_pins(ph_d);
      ack  <= (ph_d == PH_RELEASE) && (ph_q != PH_RELEASE);
    end
  end

  // Strobe-width observer for the checks below
  int unsigned we_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         we_run <= 0;
    else if (pins.we_n) we_run <= 0;
    else                we_run <= we_run + 1;
  end

  // R4
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pins.we_n) |-> (we_run == WE_CYC));

  // R9
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R2
  ack_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (pins.cs_n && !pins.dq_en));

  // R5
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pins.oe_n |-> (pins.we_n && !pins.dq_en));
endmodule

// File: rtl/asram_bus_regs.sv
module asram_bus_regs #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (capture) rdata_q <= dq_in;
    end
  end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned SETUP_CYC  = 1,
  parameter int unsigned WE_CYC     = 2,
  parameter int unsigned HOLD_CYC   = 1,
  parameter int unsigned ACCESS_CYC = 3,
  parameter int unsigned TURN_CYC   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ack,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  inout  wire  [DATA_W-1:0] mem_dq,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n
);
  localparam int unsigned MAX_CYC = max_of(SETUP_CYC, WE_CYC, HOLD_CYC,
                                           ACCESS_CYC, TURN_CYC);
  localparam int unsigned CNT_W = $clog2(MAX_CYC + 1);

  logic              accept, capture;
  pins_t             pins;
  logic [DATA_W-1:0] wdata_q;

  asram_sequencer #(
    .SETUP_CYC(SETUP_CYC), .WE_CYC(WE_CYC), .HOLD_CYC(HOLD_CYC),
    .ACCESS_CYC(ACCESS_CYC), .TURN_CYC(TURN_CYC), .CNT_W(CNT_W)
  ) i_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .accept(accept), .capture(capture), .pins(pins), .ack(req_ack)
  );

  asram_bus_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .accept(accept), .capture(capture),
    .req_addr(req_addr), .req_wdata(req_wdata), .dq_in(mem_dq),
    .addr_q(mem_addr), .wdata_q(wdata_q), .rdata_q(rsp_rdata)
  );

  assign mem_cs_n = pins.cs_n;
  assign mem_oe_n = pins.oe_n;
  assign mem_we_n = pins.we_n;
  assign mem_dq   = pins.dq_en ? wdata_q : {DATA_W{1'bz}};

  // R10
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

  // R5
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));
endmodule

// File: tb/test_asram_ctrl.sv
`timescale 1ns/1ps
module test_asram_ctrl;
  localparam int S = 1, W = 2, H = 1, A = 3, T = 2;
  localparam int WR_LAT = 1 + S + W + H;
  localparam int RD_LAT = 1 + S + A;

  // {keep_valid, write, addr[14:0], data[7:0]}
  localparam logic [24:0] VEC [10] = '{
    {1'b0, 1'b1, 15'h0000, 8'h3C},
    {1'b0, 1'b1, 15'h7FFF, 8'hC3},
    {1'b1, 1'b1, 15'h1235, 8'h5A},
    {1'b1, 1'b0, 15'h1235, 8'h00},
    {1'b0, 1'b0, 15'h0000, 8'h00},
    {1'b0, 1'b0, 15'h7FFF, 8'h00},
    {1'b1, 1'b1, 15'h0AA9, 8'hFF},
    {1'b1, 1'b1, 15'h0AA9, 8'h00},
    {1'b0, 1'b0, 15'h0AA9, 8'h00},
    {1'b0, 1'b0, 15'h1235, 8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ack, mem_cs_n, mem_oe_n, mem_we_n;
  logic [7:0]  rsp_rdata;
  logic [14:0] mem_addr;
  wire  [7:0]  mem_dq;

  int n_run = 0, n_fail = 0;
  logic [7:0] mdl [16];
  logic [7:0] shadow [16];
  logic [7:0] last_rd = 8'h00;

  always #2 clk = ~clk;

  asram_ctrl #(.SETUP_CYC(S), .WE_CYC(W), .HOLD_CYC(H), .ACCESS_CYC(A),
               .TURN_CYC(T)) i_asram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
    .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_dq(mem_dq),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
  );

  // Memory model: drives on read, stores at the end of the strobe
  assign mem_dq = (!mem_cs_n && !mem_oe_n && mem_we_n) ? mdl[mem_addr[3:0]] : 8'bz;
  always @(posedge mem_we_n) if (!mem_cs_n) mdl[mem_addr[3:0]] <= mem_dq;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_access(input logic wr, input logic [14:0] a, input logic [7:0] d,
                            input int lead, input bit keep, input bit perturb);
    int cyc = 0, hi_lead = 0, n_set = 0, n_we = 0, n_hold = 0, n_oe = 0;
    bit seen_low = 0, seen_we = 0, bad_mix = 0, bad_addr = 0, got = 0, cs_at_ack = 0;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!got && cyc < 64) begin
      @(posedge clk); @(negedge clk); cyc++;
      if (perturb && cyc == 2) begin req_addr = ~a; req_wdata = ~d; req_write = ~wr; end
      if (req_ack) begin got = 1; cs_at_ack = mem_cs_n; end
      else if (mem_cs_n) begin if (!seen_low) hi_lead++; end
      else begin
        seen_low = 1;
        if (mem_addr != a) bad_addr = 1;
        if (!mem_oe_n && !mem_we_n) bad_mix = 1;
        if (!mem_we_n) begin seen_we = 1; n_we++; end
        else if (!mem_oe_n) n_oe++;
        else if (seen_we) n_hold++;
        else n_set++;
      end
    end
    if (!keep) req_valid = 1'b0;
    chk(got && cyc == lead + (wr ? WR_LAT : RD_LAT), "R9 latency", cyc, lead + (wr ? WR_LAT : RD_LAT));
    chk(hi_lead == lead, "R11/R12 start gap", hi_lead, lead);
    chk(n_set == S, "R3 setup", n_set, S);
    chk(!bad_addr, "R10 address", int'(bad_addr), 0);
    chk(!bad_mix, "R5 oe/we overlap", int'(bad_mix), 0);
    chk(cs_at_ack == 1'b1, "R2 cs at ack", int'(cs_at_ack), 1);
    if (wr) begin
      chk(n_we == W, "R4 strobe width", n_we, W);
      chk(n_hold == H, "R6 hold", n_hold, H);
      chk(n_oe == 0, "R5 oe in write", n_oe, 0);
      chk(mdl[a[3:0]] == d, "R6 stored byte", int'(mdl[a[3:0]]), int'(d));
      chk(rsp_rdata == last_rd, "R8 held over write", int'(rsp_rdata), int'(last_rd));
      shadow[a[3:0]] = d;
    end else begin
      chk(n_oe == A, "R7 oe width", n_oe, A);
      chk(n_we == 0, "R7 strobe in read", n_we, 0);
      chk(rsp_rdata == shadow[a[3:0]], "R8 read data", int'(rsp_rdata), int'(shadow[a[3:0]]));
      last_rd = shadow[a[3:0]];
    end
    if (!keep) begin
      for (int k = 0; k < T; k++) begin
        @(posedge clk); @(negedge clk);
        chk(!req_ack, "R9 ack one cycle", int'(req_ack), 0);
        chk(mem_cs_n, "R2 release gap", int'(mem_cs_n), 1);
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin mdl[i] = 8'h00; shadow[i] = 8'h00; end
    repeat (3) @(negedge clk);
    chk(mem_cs_n && mem_oe_n && mem_we_n && !req_ack, "R1 reset pins",
        int'({mem_cs_n, mem_oe_n, mem_we_n, req_ack}), 14);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_cs_n, "R12 idle without request", int'(mem_cs_n), 1);

    for (int v = 0; v < 10; v++) begin
      automatic int lead = (v > 0 && VEC[v-1][24]) ? T - 1 : 0;
      run_access(VEC[v][23], VEC[v][22:8], VEC[v][7:0], lead, VEC[v][24], 1'b0);
    end

    // R11: request fields change mid-access
    run_access(1'b1, 15'h0004, 8'h77, 0, 1'b0, 1'b1);
    chk(mdl[4'hB] == 8'h00, "R11 perturbed address untouched", int'(mdl[4'hB]), 0);
    run_access(1'b0, 15'h0004, 8'h00, 0, 1'b0, 1'b0);

    // R1: reset in the middle of a write strobe
    req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h0006; req_wdata = 8'h99;
    repeat (3) begin @(posedge clk); @(negedge clk); end
    req_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk(mem_cs_n && mem_oe_n && mem_we_n && !req_ack, "R1 reset mid access",
        int'({mem_cs_n, mem_oe_n, mem_we_n, req_ack}), 14);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    shadow[6] = mdl[6];
    run_access(1'b0, 15'h7FFF, 8'h00, 0, 1'b0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule